// File: doc/BRIEF.md
# Two-Level Edge Interrupt Collector

This block collects a vector of single-bit event sources (32 by default) and turns transitions on them into two interrupt requests for a processor core, an urgent one and a routine one. Each source is brought into the clock domain through a short flop chain. Its rising and falling transitions are then found by comparing the synchronized level with the level one clock earlier.

Every source has its own enable for rising transitions and its own enable for falling transitions. A routing bit chooses which of the two pending registers records an enabled transition for that source. A recorded bit stays set until software reads the register that holds it, and the read also clears it. Each request line is high while its pending register is non-zero, one clock behind that register. A service routine reads the register for its own level and learns which sources to handle.

Software uses a plain synchronous port. A write strobe with an address and a data word loads a configuration register. A read strobe returns the addressed register on `rdata` one clock later.

Top module: `edge_irq_hub`

## Requirements
- R1: When `rst_n` is sampled low at a clock edge, the routing, rising-enable, falling-enable and both pending registers become zero, and both request lines are low after that edge.
- R2: Address 0 holds the routing word, address 1 the rising-enable word and address 2 the falling-enable word. A write stores `wdata` there, and a read returns the stored word on `rdata` one clock after the read strobe.
- R3: A 0-to-1 transition on a source whose rising-enable bit is 1 sets that source's bit in a pending register.
- R4: A 1-to-0 transition on a source whose falling-enable bit is 1 sets that source's bit in a pending register.
- R5: A transition whose enable bit for that direction is 0 sets no pending bit in either register.
- R6: A recorded transition goes to the urgent pending register (address 3) when the source's routing bit is 1, and to the routine pending register (address 4) when the routing bit is 0.
- R7: A pending bit stays set after its source returns to its earlier level. Only a read of its register clears it.
- R8: A read of address 3 or 4 returns the pending word and clears that register at the same clock edge.
- R9: A transition recorded at the same edge as a read clear of its register is kept, and is returned by the next read.
- R10: `irq_hi` and `irq_lo` are each high exactly when their pending register was non-zero at the previous clock edge.
- R11: Changing the routing bit of a source that is already pending leaves the bit in the register that recorded it. Only later transitions use the new routing.
- R12: Writes to addresses 3 and 4 change neither pending register.
- R13: A source with both enables set is recorded on its rising and on its falling transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NSRC | Event source levels, may be asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | NSRC | Write data |
| rdata | output | NSRC | Read data, valid the clock after `rd_en` |
| irq_hi | output | 1 | Urgent interrupt request |
| irq_lo | output | 1 | Routine interrupt request |

## Verification
The assertions assume that `rst_n` is held low for at least two clock edges. They also assume that `src` holds each new level long enough for the synchronizer to see it, because a pulse shorter than a clock can vanish without being recorded. The bench changes sources only on falling clock edges and holds each level for several clocks. It also drives strobes only on falling edges, with at most one strobe active at a time. The same-edge read and transition case is aimed by counting the synchronizer stages, so the read strobe lands exactly on the clock edge where the transition is recorded.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
   localparam int unsigned REG_ROUTE   = 0;
   localparam int unsigned REG_RISE_EN = 1;
   localparam int unsigned REG_FALL_EN = 2;
   localparam int unsigned REG_PEND_HI = 3;
   localparam int unsigned REG_PEND_LO = 4;
   localparam int unsigned REG_COUNT   = 5;
endpackage

// File: rtl/edge_sense.sv
module edge_sense #(
   parameter int unsigned NSRC        = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   output logic [NSRC-1:0] rise,
   output logic [NSRC-1:0] fall
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [NSRC-1:0] chain [SYNC_STAGES];
   logic [NSRC-1:0] prev_q;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= src;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain[LAST];
   end

   assign rise = chain[LAST] & ~prev_q;
   assign fall = ~chain[LAST] & prev_q;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs #(
   parameter int unsigned NSRC   = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NSRC-1:0]   wdata,
   output logic [NSRC-1:0]   route,
   output logic [NSRC-1:0]   rise_en,
   output logic [NSRC-1:0]   fall_en
);
   import edge_irq_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route   <= '0;
         rise_en <= '0;
         fall_en <= '0;
      end else if (wr_en) begin
         case (int'(addr))
            REG_ROUTE:   route   <= wdata;
            REG_RISE_EN: rise_en <= wdata;
            REG_FALL_EN: fall_en <= wdata;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
   parameter int unsigned NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_vec,
   input  logic            clr,
   output logic [NSRC-1:0] pend,
   output logic            irq
);
   logic [NSRC-1:0] pend_nx;
   logic            chk_ok;

   always_comb begin
      pend_nx = (clr ? '0 : pend) | set_vec;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= '0;
         irq    <= 1'b0;
         chk_ok <= 1'b0;
      end else begin
         pend   <= pend_nx;
         irq    <= |pend;
         chk_ok <= 1'b1;
      end
   end

   // Bits only drop on a read clear.
   assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      !$past(clr) |-> (($past(pend) & ~pend) == '0));

   // After a clear only freshly recorded bits remain.
   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      $past(clr) |-> ((pend & ~$past(set_vec)) == '0));

   // Request line lags the register by one clock.
   assert_req_R10: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      irq == ($past(pend) != '0));
endmodule

// File: rtl/edge_irq_hub.sv
module edge_irq_hub #(
   parameter int unsigned NSRC        = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NSRC-1:0]   wdata,
   output logic [NSRC-1:0]   rdata,
   output logic              irq_hi,
   output logic              irq_lo
);
   import edge_irq_pkg::*;

   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("edge_irq_hub: NSRC must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("edge_irq_hub: SYNC_STAGES must be at least 2");
      end
      if ((1 << ADDR_W) < REG_COUNT) begin : g_bad_addr
         $error("edge_irq_hub: ADDR_W too narrow for register map");
      end
   endgenerate

   logic [NSRC-1:0] route, rise_en, fall_en;
   logic [NSRC-1:0] rise, fall, hit;
   logic [NSRC-1:0] set_hi, set_lo;
   logic [NSRC-1:0] pend_hi, pend_lo;
   logic            clr_hi, clr_lo;
   logic [NSRC-1:0] rd_mux;
   logic            chk_ok;

   edge_sense #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_sense (
      .clk(clk), .rst_n(rst_n), .src(src), .rise(rise), .fall(fall));

   cfg_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .route(route), .rise_en(rise_en), .fall_en(fall_en));

   assign hit    = (rise & rise_en) | (fall & fall_en);
   assign set_hi = hit & route;
   assign set_lo = hit & ~route;
   assign clr_hi = rd_en && (int'(addr) == REG_PEND_HI);
   assign clr_lo = rd_en && (int'(addr) == REG_PEND_LO);

   pend_bank #(.NSRC(NSRC)) u_hi (
      .clk(clk), .rst_n(rst_n), .set_vec(set_hi), .clr(clr_hi),
      .pend(pend_hi), .irq(irq_hi));

   pend_bank #(.NSRC(NSRC)) u_lo (
      .clk(clk), .rst_n(rst_n), .set_vec(set_lo), .clr(clr_lo),
      .pend(pend_lo), .irq(irq_lo));

   always_comb begin
      case (int'(addr))
         REG_ROUTE:   rd_mux = route;
         REG_RISE_EN: rd_mux = rise_en;
         REG_FALL_EN: rd_mux = fall_en;
         REG_PEND_HI: rd_mux = pend_hi;
         REG_PEND_LO: rd_mux = pend_lo;
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         chk_ok <= 1'b0;
      end else begin
         if (rd_en) rdata <= rd_mux;
         chk_ok <= 1'b1;
      end
   end

   // New urgent bits only for sources routed urgent at that edge.
   assert_route_hi_R6: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      ((pend_hi & ~$past(pend_hi) & ~$past(route)) == '0));

   // New routine bits only for sources routed routine at that edge.
   assert_route_lo_R6: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      ((pend_lo & ~$past(pend_lo) & $past(route)) == '0));

   // No source is recorded in both registers by one transition.
   assert_one_level_R11: assert property (@(posedge clk) disable iff (!rst_n || !chk_ok)
      (((pend_hi & ~$past(pend_hi)) & (pend_lo & ~$past(pend_lo))) == '0));
endmodule

// File: tb/sim_edge_irq_hub.sv
`timescale 1ns/1ps
module sim_edge_irq_hub;
   localparam int unsigned NSRC = 32;
   localparam int unsigned AW   = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] src = '0;
   logic            wr_en = 1'b0;
   logic            rd_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [NSRC-1:0] wdata = '0;
   logic [NSRC-1:0] rdata;
   logic            irq_hi, irq_lo;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   edge_irq_hub #(.NSRC(NSRC), .SYNC_STAGES(2), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_hi(irq_hi), .irq_lo(irq_lo));

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = AW'(a);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic drive(logic [31:0] v);
      @(negedge clk);
      src = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R1 irq_hi", 32'(irq_hi), 0);
      check("R1 irq_lo", 32'(irq_lo), 0);
      for (int a = 0; a < 5; a++) begin
         rd(a, d);
         check("R1 reg", d, 0);
      end
   endtask

   task automatic t_cfg();
      logic [31:0] d;
      wr(0, 32'hA5A5_0F0F); wr(1, 32'h1234_5678); wr(2, 32'hCAFE_F00D);
      rd(0, d); check("R2 route", d, 32'hA5A5_0F0F);
      rd(1, d); check("R2 rise_en", d, 32'h1234_5678);
      rd(2, d); check("R2 fall_en", d, 32'hCAFE_F00D);
      wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
      @(negedge clk);
      check("R12 irq_hi", 32'(irq_hi), 0);
      check("R12 irq_lo", 32'(irq_lo), 0);
      rd(3, d); check("R12 pend_hi", d, 0);
      rd(4, d); check("R12 pend_lo", d, 0);
   endtask

   task automatic t_rise();
      logic [31:0] d;
      wr(0, 32'h0000_000F); wr(1, 32'h0000_00FF); wr(2, 32'h0);
      drive(32'h0000_0FF3);
      check("R10 irq_hi up", 32'(irq_hi), 1);
      check("R10 irq_lo up", 32'(irq_lo), 1);
      rd(3, d); check("R3 R6 R5 pend_hi", d, 32'h0000_0003);
      rd(3, d); check("R8 pend_hi cleared", d, 0);
      @(negedge clk);
      check("R10 irq_hi down", 32'(irq_hi), 0);
      check("R10 irq_lo held", 32'(irq_lo), 1);
      rd(4, d); check("R3 R6 pend_lo", d, 32'h0000_00F0);
   endtask

   task automatic t_fall();
      logic [31:0] d;
      wr(1, 32'h0); wr(2, 32'h00F0_00F0);
      drive(32'h0);
      rd(3, d); check("R5 pend_hi masked fall", d, 0);
      rd(4, d); check("R4 pend_lo", d, 32'h0000_00F0);
   endtask

   task automatic t_sticky();
      logic [31:0] d;
      wr(0, 32'h0001_0000); wr(1, 32'h0001_0000); wr(2, 32'h0);
      drive(32'h0001_0000);
      drive(32'h0);
      check("R7 irq_hi held", 32'(irq_hi), 1);
      rd(3, d); check("R7 pend_hi sticky", d, 32'h0001_0000);
   endtask

   task automatic t_both();
      logic [31:0] d;
      wr(0, 32'h0); wr(1, 32'h0010_0000); wr(2, 32'h0010_0000);
      drive(32'h0010_0000);
      rd(4, d); check("R13 rise", d, 32'h0010_0000);
      drive(32'h0);
      rd(4, d); check("R13 fall", d, 32'h0010_0000);
   endtask

   task automatic t_remap();
      logic [31:0] d;
      wr(0, 32'h0100_0000); wr(1, 32'h0100_0000); wr(2, 32'h0);
      drive(32'h0100_0000);
      wr(0, 32'h0); wr(2, 32'h0100_0000);
      rd(4, d); check("R11 lo untouched", d, 0);
      rd(3, d); check("R11 stays hi", d, 32'h0100_0000);
      drive(32'h0);
      rd(3, d); check("R11 new hi none", d, 0);
      rd(4, d); check("R11 new to lo", d, 32'h0100_0000);
   endtask

   task automatic t_race();
      logic [31:0] d;
      wr(0, 32'h1000_0000); wr(1, 32'h1000_0000); wr(2, 32'h0);
      @(negedge clk);
      src = 32'h1000_0000;
      @(negedge clk);            // first stage holds it
      @(negedge clk);            // second stage holds it, edge visible
      rd_en = 1'b1; addr = AW'(3);
      @(negedge clk);            // read clear and record share this edge
      rd_en = 1'b0;
      check("R9 read sees old", rdata, 0);
      rd(3, d); check("R9 kept", d, 32'h1000_0000);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg();
      t_rise();
      t_fall();
      t_sticky();
      t_both();
      t_remap();
      t_race();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule